// File: doc/BRIEF.md
# I2C Configuration Register Slave

This block lets an I2C standard-mode master (up to 100 kbit/s) program and read a small bank of configuration bytes. It oversamples SCL and SDA on the system clock, finds start and stop conditions and bit edges, and answers only its own 7-bit device address. The upper six address bits come from a parameter and the lowest bit from a strap pin. The slave never starts a transfer, never stretches the clock and pulls SDA low only, through an open-drain driver outside the block.

In a write, the first byte after the address loads an internal pointer. Each later byte is stored at the pointer, and the pointer then advances. In a read, the master first sets the pointer with a write, then sends a repeated start with the read address. The slave returns bytes from successive addresses until the master declines to acknowledge. The address space holds 28 entries, 0x00 to 0x1B. The top entry is a fixed, read-only identification byte, and the pointer returns to 0 after it. Every writable byte is presented on a flat parallel bus for the logic it configures.

Top module: `i2c_cfg_slave`

## Requirements
- R1: The slave acknowledges (holds SDA low through the ninth SCL pulse) an address byte only when its upper seven bits equal {DEV_HI, addrStrap}, with the read/write flag in bit 0 (1 = read). A mismatched address, or the all-zero general-call address, is not acknowledged, and the slave ignores the bus until the next start.
- R2: In a write, the byte after the address loads the pointer. Each following byte is stored at the pointer, which then advances. Writable register n appears on regBus[8n+7:8n].
- R3: After a pointer write, a repeated start and the read address, the slave returns the byte at the pointer, MSB first. It then returns successive addresses for as long as the master acknowledges.
- R4: After address 0x1B (NUM_REGS-1) is accessed, the pointer wraps to 0x00. This holds for both reads and writes.
- R5: Address 0x1B reads as ID_VALUE (0x12). A byte written there is acknowledged and discarded.
- R6: A pointer above 0x1B addresses nothing. Writes there are acknowledged and discarded, reads there return 0x00, and the pointer then wraps to 0x00.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start.
- R8: A start or stop inside a byte abandons that byte without storing it. After a start, the slave matches the address afresh.
- R9: During and after reset, every writable register is 0x00 and SDA is released.
- R10: The slave changes its SDA drive only while SCL is low. It drives SDA only in acknowledge slots and in read-data bits that are 0, so SDA is released whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| addrStrap | input | 1 | Lowest bit of the device address |
| sdaDriveLow | output | 1 | 1 = pull SDA low, 0 = release |
| regBus | output | (NUM_REGS-1)*8 | Contents of the writable registers, register n at bits 8n+7:8n |

## Verification
The hardest case to reach from the ports is a start or stop condition that arrives part-way through a byte, after only a few data bits. Here the bit counter and the partly shifted byte must be dropped, and nothing may be written. The bench reaches this with a bit-level task that clocks an arbitrary number of data bits. It then issues a repeated start or a stop while SCL is low, and checks both that the interrupted register is unchanged and that the next address is acknowledged. Pointer wrap through the read-only identification entry is driven by burst writes and reads that begin one entry below it. An out-of-range pointer is loaded directly to show that the wrap also applies from beyond the top entry.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } busState_t;

  // Strobes from control to datapath, each one cycle wide
  typedef struct packed {
    logic rxShift;
    logic ptrLoad;
    logic regWrite;
    logic ptrInc;
    logic txLoad;
    logic txShift;
  } strobe_t;

endpackage

// File: rtl/i2c_cfg_ctrl.sv
module i2c_cfg_ctrl
  import i2c_cfg_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [5:0]  DEV_HI      = 6'b101100
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       addrStrap,
  input  logic [7:0] rxByte,
  input  logic       txBit,
  output strobe_t    stb,
  output logic       sdaBit,
  output logic       sdaDriveLow
);

  logic [SYNC_STAGES-1:0] sclQ, sdaQ;
  logic sclD, sdaD, sclS, sdaS;
  logic sclRise, sclFall, startDet, stopDet;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= '1;
      sdaQ <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclQ <= {sclQ[SYNC_STAGES-2:0], sclIn};
      sdaQ <= {sdaQ[SYNC_STAGES-2:0], sdaIn};
      sclD <= sclQ[SYNC_STAGES-1];
      sdaD <= sdaQ[SYNC_STAGES-1];
    end
  end

  assign sclS     = sclQ[SYNC_STAGES-1];
  assign sdaS     = sdaQ[SYNC_STAGES-1];
  assign sdaBit   = sdaS;
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;

  busState_t  state, nState, afterAck, nAfter;
  logic [3:0] bitCnt, nCnt;
  logic       masterAck, nMAck;
  logic [6:0] devAddr;
  logic       addrHit;

  assign devAddr = {DEV_HI, addrStrap};
  assign addrHit = (rxByte[7:1] == devAddr) && (devAddr != 7'd0);

  always_comb begin
    nState = state;
    nAfter = afterAck;
    nCnt   = bitCnt;
    nMAck  = masterAck;
    stb    = '0;
    if (stopDet) begin
      nState = ST_IDLE;
    end else if (startDet) begin
      nState = ST_ADDR;
      nCnt   = 4'd0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && bitCnt != 4'd8) begin
            stb.rxShift = 1'b1;
            nCnt        = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            nCnt   = 4'd0;
            nState = ST_ACK;
            if (state == ST_ADDR) begin
              if (addrHit) nAfter = rxByte[0] ? ST_RDATA : ST_PTR;
              else         nState = ST_IDLE;
            end else if (state == ST_PTR) begin
              stb.ptrLoad = 1'b1;
              nAfter      = ST_WDATA;
            end else begin
              stb.regWrite = 1'b1;
              stb.ptrInc   = 1'b1;
              nAfter       = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            nState = afterAck;
            nCnt   = 4'd0;
            if (afterAck == ST_RDATA) begin
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              nState = ST_RACK;
              nCnt   = 4'd0;
            end else begin
              stb.txShift = 1'b1;
              nCnt        = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            nMAck = ~sdaS;
          end else if (sclFall) begin
            if (masterAck) begin
              nState     = ST_RDATA;
              stb.txLoad = 1'b1;
              stb.ptrInc = 1'b1;
            end else begin
              nState = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      afterAck  <= ST_IDLE;
      bitCnt    <= 4'd0;
      masterAck <= 1'b0;
    end else begin
      state     <= nState;
      afterAck  <= nAfter;
      bitCnt    <= nCnt;
      masterAck <= nMAck;
    end
  end

  assign sdaDriveLow = (state == ST_ACK) | ((state == ST_RDATA) & ~txBit);

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 28,
  parameter logic [7:0] ID_VALUE = 8'h12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobe_t                   stb,
  input  logic                      sdaBit,
  output logic [7:0]                rxByte,
  output logic                      txBit,
  output logic [(NUM_REGS-1)*8-1:0] regBus
);

  localparam int         WR_REGS  = NUM_REGS - 1;
  localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

  logic [7:0] rxSh, txSh, ptr, rdData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= 8'h00;
      txSh <= 8'hFF;
      ptr  <= 8'h00;
    end else begin
      if (stb.rxShift) rxSh <= {rxSh[6:0], sdaBit};
      if (stb.ptrLoad)     ptr <= rxSh;
      else if (stb.ptrInc) ptr <= (ptr >= LAST_IDX) ? 8'h00 : ptr + 8'h01;
      if (stb.txLoad)       txSh <= rdData;
      else if (stb.txShift) txSh <= {txSh[6:0], 1'b1};
    end
  end

  for (genvar i = 0; i < WR_REGS; i++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                q <= 8'h00;
      else if (stb.regWrite && ptr == 8'(i))    q <= rxSh;
    end
    assign regBus[i*8 +: 8] = q;
  end

  always_comb begin
    rdData = 8'h00;
    for (int i = 0; i < WR_REGS; i++)
      if (ptr == 8'(i)) rdData = regBus[i*8 +: 8];
    if (ptr == LAST_IDX) rdData = ID_VALUE;
  end

  assign rxByte = rxSh;
  assign txBit  = txSh[7];

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
  import i2c_cfg_pkg::*;
#(
  parameter int         NUM_REGS = 28,
  parameter logic [5:0] DEV_HI   = 6'b101100,
  parameter logic [7:0] ID_VALUE = 8'h12
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      sclIn,
  input  logic                      sdaIn,
  input  logic                      addrStrap,
  output logic                      sdaDriveLow,
  output logic [(NUM_REGS-1)*8-1:0] regBus
);

  strobe_t    stb;
  logic       sdaBit, txBit;
  logic [7:0] rxByte;

  i2c_cfg_ctrl #(.SYNC_STAGES(2), .DEV_HI(DEV_HI)) ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .addrStrap(addrStrap), .rxByte(rxByte), .txBit(txBit),
    .stb(stb), .sdaBit(sdaBit), .sdaDriveLow(sdaDriveLow)
  );

  i2c_cfg_regs #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) regs (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaBit(sdaBit),
    .rxByte(rxByte), .txBit(txBit), .regBus(regBus)
  );

endmodule

// File: rtl/i2c_cfg_chk.sv
module i2c_cfg_chk #(
  parameter int BUS_W = 216
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaDriveLow,
  input logic [BUS_W-1:0] regBus
);

  localparam int NBYTES = BUS_W / 8;

  logic [BUS_W-1:0]  prevBus;
  logic              prevDrive;
  logic [NBYTES-1:0] byteChg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevBus   <= '0;
      prevDrive <= 1'b0;
    end else begin
      prevBus   <= regBus;
      prevDrive <= sdaDriveLow;
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_chg
    assign byteChg[i] = regBus[i*8 +: 8] != prevBus[i*8 +: 8];
  end

  AST_SINGLE_BYTE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(byteChg)); // R2

  AST_REG_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (byteChg != '0) |-> !sclIn); // R8

  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDriveLow != prevDrive) |-> !sclIn); // R10

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!sdaDriveLow && regBus == '0); // R9
    end
  end

endmodule

bind i2c_cfg_slave i2c_cfg_chk #(.BUS_W((NUM_REGS-1)*8)) chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn),
  .sdaDriveLow(sdaDriveLow), .regBus(regBus)
);

// File: tb/i2c_cfg_slave_test.sv
module i2c_cfg_slave_test;

  localparam int NREG  = 28;
  localparam int WRN   = NREG - 1;
  localparam int Q     = 10;
  localparam logic [7:0] WADDR = 8'hB2;
  localparam logic [7:0] RADDR = 8'hB3;
  // {pointer, write data, expected read}
  localparam logic [23:0] VEC [7] = '{
    24'h00A5A5, 24'h053C3C, 24'h1AFFFF, 24'h1B7712,
    24'h305500, 24'h0C0000, 24'h118181
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN;
  logic mScl = 1'b1, mSda = 1'b1;
  logic strap = 1'b1;
  logic sdaDriveLow, sdaLine;
  logic [WRN*8-1:0] regBus;

  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_cfg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine),
    .addrStrap(strap), .sdaDriveLow(sdaDriveLow), .regBus(regBus)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] model [WRN];

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pause();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    mSda = 1'b1; pause(); mScl = 1'b1; pause();
    mSda = 1'b0; pause(); mScl = 1'b0; pause();
  endtask

  task automatic busStop();
    mSda = 1'b0; pause(); mScl = 1'b1; pause(); mSda = 1'b1; pause();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      mSda = b[7-i]; pause(); mScl = 1'b1; pause(); mScl = 1'b0; pause();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    sendBits(b, 8);
    mSda = 1'b1; pause(); mScl = 1'b1; pause();
    ack = !sdaLine;
    mScl = 1'b0; pause();
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      pause(); mScl = 1'b1; pause(); b[i] = sdaLine; mScl = 1'b0; pause();
    end
    mSda = giveAck ? 1'b0 : 1'b1; pause(); mScl = 1'b1; pause(); mScl = 1'b0; pause();
    mSda = 1'b1;
  endtask

  task automatic modelWrite(input logic [7:0] ptr, input logic [7:0] d [4], input int n);
    int p = int'(ptr);
    for (int i = 0; i < n; i++) begin
      if (p < WRN) model[p] = d[i];
      p = (p >= WRN) ? 0 : p + 1;
    end
  endtask

  task automatic writeRegs(input string tag, input logic [7:0] ptr,
                           input logic [7:0] d [4], input int n);
    bit ack;
    busStart();
    sendByte(WADDR, ack); chkEq({tag, " R1 address ack"}, ack, 1);
    sendByte(ptr, ack);   chkEq({tag, " R2 pointer ack"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      sendByte(d[i], ack); chkEq({tag, " R2 data ack"}, ack, 1);
    end
    busStop();
    chkEq({tag, " R10 released after stop"}, sdaDriveLow, 0);
    modelWrite(ptr, d, n);
  endtask

  task automatic readRegs(input logic [7:0] ptr, input int n, output logic [7:0] r [4]);
    bit ack;
    busStart();
    sendByte(WADDR, ack); chkEq("R3 address ack", ack, 1);
    sendByte(ptr, ack);   chkEq("R3 pointer ack", ack, 1);
    busStart();
    sendByte(RADDR, ack); chkEq("R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, r[i]);
    busStop();
  endtask

  task automatic checkBus(input string tag);
    for (int i = 0; i < WRN; i++) chkEq(tag, regBus[i*8 +: 8], model[i]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d [4];
    logic [7:0] r [4];
    bit ack;
    for (int i = 0; i < WRN; i++) model[i] = 8'h00;

    rstN = 1'b0;
    repeat (5) @(negedge clk);
    chkEq("R9 drive in reset", sdaDriveLow, 0);
    chkEq("R9 regs in reset", (regBus == '0), 1);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkBus("R9 regs after reset");

    // R1: wrong strap bit, then a byte the idle slave must ignore
    busStart();
    sendByte(8'hB0, ack); chkEq("R1 mismatch no ack", ack, 0);
    sendByte(8'h00, ack); chkEq("R1 ignored until start", ack, 0);
    busStop();
    busStart();
    sendByte(8'h00, ack); chkEq("R1 general call no ack", ack, 0);
    busStop();

    // Vector walk: single write then read-back
    for (int v = 0; v < 7; v++) begin
      d[0] = VEC[v][15:8];
      writeRegs("vector", VEC[v][23:16], d, 1);
      readRegs(VEC[v][23:16], 1, r);
      chkEq("R3/R5/R6 vector read", r[0], VEC[v][7:0]);
    end
    checkBus("R2 vector bus");

    // R4/R5: burst write crossing the ID entry
    d = '{8'h11, 8'h22, 8'h33, 8'h44};
    writeRegs("burst", 8'h1A, d, 4);
    checkBus("R4 burst write wrap");
    readRegs(8'h1A, 4, r);
    chkEq("R4 read 0x1A", r[0], 8'h11);
    chkEq("R5 read ID", r[1], 8'h12);
    chkEq("R4 read wrapped 0x00", r[2], 8'h33);
    chkEq("R4 read 0x01", r[3], 8'h44);

    // R7: after NACK the slave stays off the bus
    busStart();
    sendByte(WADDR, ack); sendByte(8'h00, ack);
    busStart();
    sendByte(RADDR, ack); chkEq("R7 read address ack", ack, 1);
    recvByte(1'b0, r[0]); chkEq("R7 last byte", r[0], 8'h33);
    recvByte(1'b1, r[1]); chkEq("R7 silent after nack", r[1], 8'hFF);
    chkEq("R7 released", sdaDriveLow, 0);
    busStop();

    // R8: repeated start after four data bits
    busStart();
    sendByte(WADDR, ack); sendByte(8'h03, ack);
    sendBits(8'hA0, 4);
    busStart();
    sendByte(WADDR, ack); chkEq("R8 ack after mid-byte start", ack, 1);
    sendByte(8'h04, ack); sendByte(8'h5A, ack);
    busStop();
    model[4] = 8'h5A;
    checkBus("R8 abort by start");

    // R8: stop after three data bits
    busStart();
    sendByte(WADDR, ack); sendByte(8'h05, ack);
    sendBits(8'hE0, 3);
    busStop();
    d[0] = 8'h6B;
    writeRegs("R8 after mid-byte stop", 8'h06, d, 1);
    checkBus("R8 abort by stop");

    // R6: out-of-range pointer discards then wraps to 0
    d = '{8'h99, 8'h77, 8'h00, 8'h00};
    writeRegs("R6 out of range", 8'h40, d, 2);
    checkBus("R6 out of range bus");
    readRegs(8'h40, 2, r);
    chkEq("R6 read out of range", r[0], 8'h00);
    chkEq("R6 wrap to 0", r[1], 8'h77);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule